// File: doc/BRIEF.md
# Two-Block Ping-Pong Result Mover

This block takes each 16-bit conversion result as it arrives and writes it into word-addressed system memory. The region it writes is split into two equal blocks of n words that lie next to each other. The block fills the first block, then the second, then returns to the first. Software can therefore read one block while the hardware fills the other.

Software programs a 16-bit start address, the word count n and an enable bit through a small write-only register port. Internally the block keeps a hidden write pointer and a hidden remaining-word counter. It drives a single-beat memory write port with address, data, valid and ready. Each time a block fills, the block raises a sticky interrupt flag and sets a status bit that names the half just completed. A two-entry holding stage absorbs results that arrive while a write is stalled. A sticky overrun bit records any result it had to drop.

Top module: `pingpong_xfer`

## Requirements
- R1: The configuration selector `cfg_sel` decodes as 0 = start address, 1 = word count n (low bits of `cfg_wdata`) and 2 = control (bit 0 = enable). A write to selector 0, 1 or 2 restarts the block: the pointer is set to the new start address, the counter is set to the new n, `blk_status` clears and any held results are discarded. After reset, `mem_valid`, `irq`, `blk_status` and `overrun` are 0.
- R2: After a restart, the first write goes to the start address SA. The first block covers SA up to SA+2n-2.
- R3: Each completed write (`mem_valid` and `mem_ready` both high) moves the write address forward by 2 bytes.
- R4: The n-th completed write of the first block sets `irq` and sets `blk_status` to 1.
- R5: The next result after the first block fills is written to SA+2n. The n-th write of the second block sets `irq` and clears `blk_status` to 0.
- R6: The write that follows the end of the second block goes to SA again.
- R7: `irq` stays at 1 until software writes 1 to bit 0 at `cfg_sel` = 3. If a clear and a new block end fall in the same cycle, the new block end wins and `irq` stays at 1.
- R8: While the enable bit is 0 or n is 0, arriving results are ignored. No write is issued and no flag changes.
- R9: Once `mem_valid` is raised, it stays high with unchanged address and data until `mem_ready` is seen.
- R10: One result that arrives while a write is stalled is held. Results are written in the order they arrived.
- R11: A result that arrives while both holding entries are full is dropped and sets `overrun`. `overrun` stays at 1 until software writes 1 to bit 1 at `cfg_sel` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| res_valid | input | 1 | New conversion result present |
| res_data | input | 16 | Conversion result |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory byte address |
| mem_data | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write |
| irq | output | 1 | Block-full interrupt flag |
| blk_status | output | 1 | 1 after the first block fills, 0 after the second |
| overrun | output | 1 | Sticky dropped-result flag |

## Verification
The assertions assume that software changes the configuration only while the write port is idle, with nothing held and no result arriving in that cycle. They also assume that `mem_ready` has meaning only while `mem_valid` is high. The stimulus drains the holding stage and lets several quiet cycles pass before every configuration write other than a flag clear. Between those points, results and `mem_ready` are toggled freely, so stalls, refills and overruns happen often while the address walk stays intact.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLEAR = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs
  import pp_pkg::*;
#(
  parameter int AW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_nx,
  output logic [NW-1:0] count_nx,
  output logic          active,
  output logic          restart,
  output logic          irq_clr,
  output logic          ovr_clr
);
  logic [AW-1:0] base_q;
  logic [NW-1:0] count_q;
  logic          en_q, en_d;

  always_comb begin
    base_nx  = base_q;
    count_nx = count_q;
    en_d     = en_q;
    restart  = 1'b0;
    irq_clr  = 1'b0;
    ovr_clr  = 1'b0;
    if (cfg_wr) begin
      unique case (cfg_sel_e'(cfg_sel))
        SEL_BASE:  begin base_nx  = cfg_wdata;           restart = 1'b1; end
        SEL_COUNT: begin count_nx = cfg_wdata[NW-1:0];   restart = 1'b1; end
        SEL_CTRL:  begin en_d     = cfg_wdata[0];        restart = 1'b1; end
        SEL_CLEAR: begin irq_clr  = cfg_wdata[0]; ovr_clr = cfg_wdata[1]; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      count_q <= '0;
      en_q    <= 1'b0;
    end else if (cfg_wr) begin
      base_q  <= base_nx;
      count_q <= count_nx;
      en_q    <= en_d;
    end
  end

  assign active = en_q && (count_q != '0);
endmodule

// File: rtl/pp_stage.sv
module pp_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          out_ready,
  input  logic          ovr_clr,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          fire,
  output logic          overrun
);
  logic          hv_q, hv_d, bv_q, bv_d, ovr_q, ovr_d, ovr_set;
  logic [DW-1:0] hd_q, hd_d, bd_q, bd_d;

  assign fire = hv_q && out_ready;

  always_comb begin
    hv_d    = hv_q;
    hd_d    = hd_q;
    bv_d    = bv_q;
    bd_d    = bd_q;
    ovr_set = 1'b0;
    if (flush) begin
      hv_d = 1'b0;
      bv_d = 1'b0;
    end else begin
      if (fire) begin
        hv_d = bv_q;
        hd_d = bd_q;
        bv_d = 1'b0;
      end
      if (in_valid) begin
        if (!hv_d) begin
          hv_d = 1'b1;
          hd_d = in_data;
        end else if (!bv_d) begin
          bv_d = 1'b1;
          bd_d = in_data;
        end else begin
          ovr_set = 1'b1;
        end
      end
    end
    ovr_d = (ovr_q && !ovr_clr) || ovr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q  <= 1'b0;
      bv_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      hv_q  <= hv_d;
      bv_q  <= bv_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    hd_q <= hd_d;
    bd_q <= bd_d;
  end

  assign out_valid = hv_q;
  assign out_data  = hd_q;
  assign overrun   = ovr_q;

  AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    hv_q && !out_ready && !flush |=> hv_q && $stable(out_data)); // R9
  AST_BUFFER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    fire && bv_q && !flush |=> hv_q && (out_data == $past(bd_q))); // R10
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !ovr_clr |=> ovr_q); // R11
endmodule

// File: rtl/pp_walker.sv
module pp_walker #(
  parameter int AW = 16,
  parameter int NW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [AW-1:0] base_nx,
  input  logic [NW-1:0] count_nx,
  input  logic [AW-1:0] base,
  input  logic [NW-1:0] count,
  input  logic          fire,
  input  logic          irq_clr,
  output logic [AW-1:0] ptr,
  output logic          irq,
  output logic          status
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);
  localparam logic [NW-1:0] LAST = NW'(1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d, st_q, st_d, irq_q, irq_d, at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    half_d = half_q;
    st_d   = st_q;
    irq_d  = irq_q && !irq_clr;
    if (restart) begin
      ptr_d  = base_nx;
      cnt_d  = count_nx;
      half_d = 1'b0;
      st_d   = 1'b0;
    end else if (fire) begin
      if (at_last) begin
        cnt_d  = count;
        irq_d  = 1'b1;
        st_d   = !half_q;
        half_d = !half_q;
        ptr_d  = half_q ? base : ptr_q + STEP;
      end else begin
        cnt_d = cnt_q - LAST;
        ptr_d = ptr_q + STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      st_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      st_q   <= st_d;
      irq_q  <= irq_d;
    end
  end

  assign ptr    = ptr_q;
  assign irq    = irq_q;
  assign status = st_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !restart && !(at_last && half_q) |=> ptr_q == $past(ptr_q) + STEP); // R3
  AST_FIRST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !restart && at_last && !half_q |=> st_q && irq_q); // R4
  AST_SECOND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !restart && at_last && half_q |=> !st_q && irq_q); // R5
  AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !restart && at_last && half_q |=> ptr_q == base); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q); // R7
endmodule

// File: rtl/pingpong_xfer.sv
module pingpong_xfer #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  output logic          irq,
  output logic          blk_status,
  output logic          overrun
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [AW-1:0] base_nx, base_q;
  logic [NW-1:0] count_nx, count_q;
  logic          active, restart, irq_clr, ovr_clr, fire;

  pp_cfg_regs #(.AW(AW), .NW(NW)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_nx(base_nx), .count_nx(count_nx),
    .active(active), .restart(restart), .irq_clr(irq_clr), .ovr_clr(ovr_clr)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      base_q  <= '0;
      count_q <= '0;
    end else if (restart) begin
      base_q  <= base_nx;
      count_q <= count_nx;
    end
  end

  pp_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_int_n), .flush(restart),
    .in_valid(res_valid && active), .in_data(res_data),
    .out_ready(mem_ready), .ovr_clr(ovr_clr),
    .out_valid(mem_valid), .out_data(mem_data), .fire(fire), .overrun(overrun)
  );

  pp_walker #(.AW(AW), .NW(NW), .DW(DW)) u_walk (
    .clk(clk), .rst_n(rst_int_n), .restart(restart),
    .base_nx(base_nx), .count_nx(count_nx), .base(base_q), .count(count_q),
    .fire(fire), .irq_clr(irq_clr), .ptr(mem_addr), .irq(irq), .status(blk_status)
  );

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    !active |-> !mem_valid); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart |=> !blk_status && !mem_valid && (mem_addr == base_q)); // R1
endmodule

// File: tb/pingpong_xfer_test.sv
module pingpong_xfer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = 16'd0;
  logic        mem_ready = 1'b0;
  logic        mem_valid, irq, blk_status, overrun;
  logic [15:0] mem_addr, mem_data;

  always #2.5 clk = ~clk;

  pingpong_xfer uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_data(res_data),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .irq(irq), .blk_status(blk_status), .overrun(overrun)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference
  logic [15:0] q[$];
  int  m_sa, m_n, m_ptr, m_cnt;
  bit  m_ctl, m_blk, m_irq, m_st, m_ovr, m_fire;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete();
      m_sa = 0; m_n = 0; m_ptr = 0; m_cnt = 0;
      m_ctl = 0; m_blk = 0; m_irq = 0; m_st = 0; m_ovr = 0;
    end else begin
      m_fire = (q.size() > 0) && mem_ready;
      if (cfg_wr && cfg_sel != 2'd3) begin
        if (cfg_sel == 2'd0) m_sa = cfg_wdata;
        if (cfg_sel == 2'd1) m_n = cfg_wdata[7:0];
        if (cfg_sel == 2'd2) m_ctl = cfg_wdata[0];
        q.delete();
        m_ptr = m_sa; m_cnt = m_n; m_blk = 0; m_st = 0;
      end else begin
        if (cfg_wr && cfg_wdata[0]) m_irq = 0;
        if (cfg_wr && cfg_wdata[1]) m_ovr = 0;
        if (m_fire) begin
          void'(q.pop_front());
          if (m_cnt == 1) begin
            m_cnt = m_n; m_irq = 1; m_st = !m_blk;
            m_ptr = m_blk ? m_sa : (m_ptr + 2) & 16'hFFFF;
            m_blk = !m_blk;
          end else begin
            m_cnt = m_cnt - 1;
            m_ptr = (m_ptr + 2) & 16'hFFFF;
          end
        end
        if (res_valid && m_ctl && m_n != 0) begin
          if (q.size() < 2) q.push_back(res_data);
          else m_ovr = 1;
        end
      end
    end
  end

  // Port log and per-cycle comparison
  logic [15:0] log_a[$];
  logic [15:0] log_d[$];

  always @(negedge clk) begin
    if (cyc >= 2) begin
      chk(mem_valid === (q.size() > 0), "R9 mem_valid", mem_valid, q.size() > 0);
      if (q.size() > 0) begin
        chk(mem_addr === m_ptr[15:0], "R3 mem_addr", mem_addr, m_ptr);
        chk(mem_data === q[0], "R10 mem_data", mem_data, q[0]);
      end
      chk(irq === m_irq, "R7 irq", irq, m_irq);
      chk(blk_status === m_st, "R4 blk_status", blk_status, m_st);
      chk(overrun === m_ovr, "R11 overrun", overrun, m_ovr);
      if (mem_valid && mem_ready) begin
        log_a.push_back(mem_addr);
        log_d.push_back(mem_data);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    res_valid = 1'b0;
  endtask

  task automatic cfgw(input logic [1:0] s, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    tick();
  endtask

  task automatic res(input logic [15:0] d);
    res_valid = 1'b1; res_data = d;
    tick();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base_n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    chk(!mem_valid && !irq && !blk_status && !overrun, "R1 reset state",
        {mem_valid, irq, blk_status, overrun}, 0);

    // R8: ignored while disabled
    mem_ready = 1'b1;
    res(16'h0AA1); res(16'h0AA2); idle(3);
    cfgw(2'd0, 16'h1000); cfgw(2'd1, 16'd3);
    res(16'h0AA3); idle(3);
    chk(log_a.size() == 0, "R8 no write while disabled", log_a.size(), 0);
    chk(!irq && !overrun, "R8 flags untouched", {irq, overrun}, 0);

    cfgw(2'd2, 16'd1); idle(2);
    // first block
    res(16'h0101); tick(); res(16'h0102); tick(); res(16'h0103); tick();
    chk(log_a.size() == 3 && log_a[0] == 16'h1000, "R2 first at base", log_a[0], 16'h1000);
    chk(log_a[2] == 16'h1004, "R2 end of first block", log_a[2], 16'h1004);
    chk(blk_status && irq, "R4 first block full", {blk_status, irq}, 2'b11);
    cfgw(2'd3, 16'd1);
    chk(!irq, "R7 irq cleared", irq, 0);
    res(16'h0104); tick(); res(16'h0105); tick(); res(16'h0106); tick();
    chk(log_a[3] == 16'h1006, "R5 second block start", log_a[3], 16'h1006);
    chk(!blk_status && irq, "R5 second block full", {blk_status, irq}, 2'b01);
    res(16'h0107); tick();
    chk(log_a[6] == 16'h1000, "R6 wrap to base", log_a[6], 16'h1000);

    // R10, R11: stall, buffer and overrun
    mem_ready = 1'b0;
    base_n = log_d.size();
    res(16'h0C01); res(16'h0C02); res(16'h0C03); tick();
    chk(overrun, "R11 overrun set", overrun, 1);
    chk(mem_valid && mem_data == 16'h0C01, "R9 held request", mem_data, 16'h0C01);
    mem_ready = 1'b1;
    idle(4);
    chk(log_d.size() == base_n + 2, "R11 newest dropped", log_d.size(), base_n + 2);
    chk(log_d[base_n] == 16'h0C01 && log_d[base_n+1] == 16'h0C02, "R10 order",
        log_d[base_n+1], 16'h0C02);
    cfgw(2'd3, 16'd2);
    chk(!overrun, "R11 overrun cleared", overrun, 0);

    // R1: restart with a new base
    cfgw(2'd0, 16'h2000); idle(2);
    chk(!blk_status, "R1 status cleared on restart", blk_status, 0);
    res(16'h0D01); tick();
    chk(log_a[log_a.size()-1] == 16'h2000, "R1 restart address", log_a[log_a.size()-1], 16'h2000);

    // free-running traffic, reference compared every cycle
    for (int r = 0; r < 4; r++) begin
      idle(4);
      cfgw(2'd1, 16'(r + 1));
      cfgw(2'd0, 16'h3000 + 16'(r * 16'h0100));
      for (int i = 0; i < 3000; i++) begin
        mem_ready = ($urandom % 3) != 0;
        if (($urandom % 97) == 0) begin cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_wdata = 16'($urandom % 4); end
        res_valid = ($urandom % 3) == 0;
        res_data = 16'($urandom);
        tick();
      end
      mem_ready = 1'b1;
    end

    // R8: n = 0 disables
    idle(4);
    cfgw(2'd1, 16'd0);
    base_n = log_a.size();
    res(16'h0E01); res(16'h0E02); idle(3);
    chk(log_a.size() == base_n, "R8 zero count disables", log_a.size(), base_n);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule